// File: doc/BRIEF.md
# PCM Voice Serial Port Controller

This block is the bit-clock side of a single-channel telephony voice codec. It works in a fast system-clock domain and treats the serial bit clock, the two frame syncs and the serial receive data as asynchronous inputs. It passes each of them through a two-stage synchronizer and then finds bit-clock edges in the synchronized copies. The receive path waits for a rising receive frame sync and then assembles one 8-bit sample, most significant bit first, from the serial input on falling bit-clock edges. It presents the sample on a parallel output with a one-cycle valid pulse.

The transmit path has its own frame sync. When the transmit sync is newly high at a rising bit-clock edge, the path launches the held 8-bit sample. It drives one bit per rising edge, so that each bit is stable when the far end samples it on the falling edge. Output enable is high for exactly those eight bit times, and the line is released for the rest of the frame. A parallel sample with a valid strobe loads the hold register. The same sample is sent again in each frame until a new one arrives.

Two activity watchdogs count system cycles since the last edge of the bit clock and since the last edge of the transmit sync. If either input stays at one level for longer than the timeout, the block enters a power-saving state. A power-down input forces a power-down state. In either of these states the serial output is released and no receive sample is reported.

Power states and transitions (register `pwr_state`):
- RUN (00) goes to SAVE when a watchdog expires.
- RUN goes to DOWN when `pwr_down` is high.
- SAVE goes to RUN once both watched inputs toggle again.
- SAVE goes to DOWN when `pwr_down` is high.
- DOWN goes to SAVE or RUN when `pwr_down` falls. SAVE is chosen if a watchdog is still expired.

Receive states:
- RX_OFF goes to RX_HUNT when the power state is RUN.
- RX_HUNT goes to RX_SHIFT when a sync rise is seen.
- RX_SHIFT goes back to RX_HUNT after the eighth bit.
- Any receive state goes to RX_OFF when the power state leaves RUN.

Transmit states:
- TX_OFF goes to TX_WAIT when the power state is RUN.
- TX_WAIT goes to TX_SHIFT on a launch.
- TX_SHIFT goes back to TX_WAIT at the ninth rising edge.
- Any transmit state goes to TX_OFF when the power state leaves RUN.

Top module: `voice_serial_port`

## Requirements
- R1: After reset, `rx_valid` and `tx_oe` are 0 and `pwr_state` is 00 (RUN).
- R2: A falling bit-clock edge at which `rx_fsync` is high, where it was low at the previous falling edge, captures the first (most significant) bit of a receive sample. The next seven falling edges capture the remaining bits. After the eighth bit, `rx_sample` holds the byte and `rx_valid` pulses for one cycle.
- R3: One sync rise yields exactly one sample. A sync held high for several bits does not start a second sample, and serial bits outside the eight-bit window do not reach `rx_sample`.
- R4: A rising bit-clock edge at which `tx_fsync` is newly high drives the most significant bit of the launched sample on `tx_sdata` with `tx_oe` high. The next seven rising edges drive the remaining bits. At the ninth rising edge `tx_oe` goes low and stays low until the next launch.
- R5: The receive and transmit frame positions are independent. Either sync may sit at any bit of the frame.
- R6: `tx_valid` loads `tx_sample` into a hold register. Each launch sends the latest held value, and a sample is sent again when no new one has arrived.
- R7: An edge on an asynchronous input takes effect at the third rising system-clock edge after it is applied. A `tx_valid` strobe sampled at that same edge as a launch is sent in that frame. A strobe one cycle later waits for the next frame.
- R8: If the bit clock stays at one level for more than `STALL_LIMIT` system cycles, `pwr_state` becomes 01 (SAVE).
- R9: If `tx_fsync` stays at one level for more than `STALL_LIMIT` system cycles, `pwr_state` becomes 01 (SAVE).
- R10: `pwr_down` high moves `pwr_state` to 10 (DOWN) at the next clock edge, whatever the watchdog state.
- R11: While `pwr_state` is not RUN, `tx_oe` stays low, `rx_valid` never pulses, and sample captures and launches are not carried out.
- R12: A watchdog clears at the first edge of its input. `pwr_state` returns to RUN once both watched inputs are active and `pwr_down` is low, and normal framing then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| rx_fsync | input | 1 | Receive frame sync, rising edge marks first bit |
| rx_sdata | input | 1 | Serial receive data |
| tx_fsync | input | 1 | Transmit frame sync, rising edge launches a sample |
| pwr_down | input | 1 | Forces the power-down state |
| tx_sample | input | SAMPLE_W | Parallel sample to transmit |
| tx_valid | input | 1 | Loads `tx_sample` into the hold register |
| rx_sample | output | SAMPLE_W | Last received sample |
| rx_valid | output | 1 | One-cycle pulse when `rx_sample` is updated |
| tx_sdata | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for `tx_sdata` (low means released) |
| pwr_state | output | 2 | 00 RUN, 01 SAVE, 10 DOWN |

## Verification
Two events can fall in the same system cycle: the transmit launch, which is triggered by a synchronized rising bit-clock edge with the transmit sync newly high, and a parallel `tx_valid` load. Because the input latency is fixed at three clock edges, the bench can pulse `tx_valid` exactly at the launch edge in one frame and one cycle after it in another. The scoreboard expects the new byte in the first case and the previously held byte in the second. A frame that loads a sample well before its launch, and one that loads a sample after its launch, bracket these two cases.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

    typedef enum logic [1:0] {
        PW_RUN  = 2'd0,
        PW_SAVE = 2'd1,
        PW_DOWN = 2'd2
    } pw_state_e;

    typedef enum logic [1:0] {
        RX_OFF   = 2'd0,
        RX_HUNT  = 2'd1,
        RX_SHIFT = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_OFF   = 2'd0,
        TX_WAIT  = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

endpackage

// File: rtl/vsp_sync.sv
// Multi-bit level synchronizer: STAGES flops per bit.
module vsp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/vsp_stall_watch.sv
// Activity watchdog: flags a signal that has not toggled for LIMIT cycles.
module vsp_stall_watch #(
    parameter int LIMIT = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    output logic stalled
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
            stalled   <= 1'b0;
        end else if (toggle) begin
            quiet_cnt <= '0;
            stalled   <= 1'b0;
        end else if (quiet_cnt == CW'(LIMIT)) begin
            stalled   <= 1'b1;
        end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R12: any edge clears the flag
    a_r12_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> !stalled);
    // R8/R9: flag only rises after a quiet cycle
    a_r8_rise_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stalled) |-> $past(!toggle));
endmodule

// File: rtl/vsp_rx.sv
// Receive deframer: picks one sample after each receive sync rise.
module vsp_rx
    import vsp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         bit_fall,
    input  logic         sync_lvl,
    input  logic         din,
    output logic [W-1:0] sample,
    output logic         valid
);
    localparam int CW = $clog2(W + 1);

    rx_state_e     st, st_nx;
    logic [W-1:0]  shreg;
    logic [CW-1:0] cnt;
    logic          sync_prev;
    logic          start;
    logic          last;

    assign start = bit_fall && sync_lvl && !sync_prev;
    assign last  = bit_fall && (st == RX_SHIFT) && (cnt == CW'(W - 1)) && !start;

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_OFF:   if (run) st_nx = RX_HUNT;
            RX_HUNT:  begin
                if (!run)       st_nx = RX_OFF;
                else if (start) st_nx = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (!run)       st_nx = RX_OFF;
                else if (start) st_nx = RX_SHIFT;
                else if (last)  st_nx = RX_HUNT;
            end
            default:            st_nx = RX_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_OFF;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            sync_prev <= 1'b0;
            sample    <= '0;
            valid     <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (bit_fall) sync_prev <= sync_lvl;
            if (run && st != RX_OFF) begin
                if (start) begin
                    shreg <= {shreg[W-2:0], din};
                    cnt   <= CW'(1);
                end else if (st == RX_SHIFT && bit_fall) begin
                    shreg <= {shreg[W-2:0], din};
                    cnt   <= cnt + 1'b1;
                    if (cnt == CW'(W - 1)) begin
                        sample <= {shreg[W-2:0], din};
                        valid  <= 1'b1;
                    end
                end
            end
        end
    end

    // R11: nothing reported outside RUN
    a_r11_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !valid);
    // R2: valid is a single-cycle pulse
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R2: a sample completes only on a falling bit-clock edge
    a_r2_valid_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(bit_fall));
endmodule

// File: rtl/vsp_tx.sv
// Transmit framer: launches the held sample after each transmit sync rise.
module vsp_tx
    import vsp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         bit_rise,
    input  logic         sync_lvl,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         sdata,
    output logic         oe
);
    localparam int CW = $clog2(W + 1);

    tx_state_e     st, st_nx;
    logic [W-1:0]  hold;
    logic [W-1:0]  shreg;
    logic [W-1:0]  launch_word;
    logic [CW-1:0] cnt;
    logic          sync_prev;
    logic          start;
    logic          done;

    assign start       = bit_rise && sync_lvl && !sync_prev;
    assign done        = bit_rise && (st == TX_SHIFT) && (cnt == CW'(W)) && !start;
    assign launch_word = load ? load_data : hold;   // same-cycle load wins

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_OFF:   if (run) st_nx = TX_WAIT;
            TX_WAIT:  begin
                if (!run)       st_nx = TX_OFF;
                else if (start) st_nx = TX_SHIFT;
            end
            TX_SHIFT: begin
                if (!run)       st_nx = TX_OFF;
                else if (start) st_nx = TX_SHIFT;
                else if (done)  st_nx = TX_WAIT;
            end
            default:            st_nx = TX_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_OFF;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            shreg     <= '0;
            cnt       <= '0;
            sync_prev <= 1'b0;
            sdata     <= 1'b0;
            oe        <= 1'b0;
        end else begin
            if (load)     hold      <= load_data;
            if (bit_rise) sync_prev <= sync_lvl;
            if (!run || st == TX_OFF) begin
                sdata <= 1'b0;
                oe    <= 1'b0;
            end else if (start) begin
                sdata <= launch_word[W-1];
                shreg <= {launch_word[W-2:0], 1'b0};
                cnt   <= CW'(1);
                oe    <= 1'b1;
            end else if (done) begin
                sdata <= 1'b0;
                oe    <= 1'b0;
            end else if (st == TX_SHIFT && bit_rise) begin
                sdata <= shreg[W-1];
                shreg <= {shreg[W-2:0], 1'b0};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // R11: line released outside RUN
    a_r11_tx_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !oe);
    // R4: serial outputs only move at a rising bit-clock edge
    a_r4_move_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bit_rise) |=> ($stable(oe) && $stable(sdata)));
    // R4: the enable is raised only by a launch
    a_r4_oe_from_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(bit_rise && sync_lvl));
endmodule

// File: rtl/voice_serial_port.sv
module voice_serial_port
    import vsp_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int STALL_LIMIT = 62500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                rx_fsync,
    input  logic                rx_sdata,
    input  logic                tx_fsync,
    input  logic                pwr_down,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic                tx_valid,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid,
    output logic                tx_sdata,
    output logic                tx_oe,
    output logic [1:0]          pwr_state
);
    localparam int NIN   = 4;
    localparam int NWAT  = 2;
    localparam int I_BCK = 0;
    localparam int I_RFS = 1;
    localparam int I_RSD = 2;
    localparam int I_TFS = 3;

    logic [NIN-1:0]  raw_in;
    logic [NIN-1:0]  lvl;
    logic [NWAT-1:0] watch_lvl;
    logic [NWAT-1:0] watch_dly;
    logic [NWAT-1:0] watch_tog;
    logic [NWAT-1:0] stalled;
    logic            bit_rise;
    logic            bit_fall;
    logic            run;
    pw_state_e       pw_st, pw_nx;

    assign raw_in = {tx_fsync, rx_sdata, rx_fsync, bclk};

    vsp_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .lvl   (lvl)
    );

    // watched signals: bit 0 bit clock, bit 1 transmit sync
    assign watch_lvl = {lvl[I_TFS], lvl[I_BCK]};

    always_ff @(posedge clk) begin
        if (!rst_n) watch_dly <= '0;
        else        watch_dly <= watch_lvl;
    end

    assign watch_tog = watch_lvl ^ watch_dly;
    assign bit_rise  = watch_lvl[0] && !watch_dly[0];
    assign bit_fall  = !watch_lvl[0] && watch_dly[0];

    for (genvar g = 0; g < NWAT; g++) begin : g_watch
        vsp_stall_watch #(.LIMIT(STALL_LIMIT)) u_watch (
            .clk     (clk),
            .rst_n   (rst_n),
            .toggle  (watch_tog[g]),
            .stalled (stalled[g])
        );
    end

    // power state machine
    always_comb begin
        pw_nx = pw_st;
        unique case (pw_st)
            PW_RUN: begin
                if (pwr_down)      pw_nx = PW_DOWN;
                else if (|stalled) pw_nx = PW_SAVE;
            end
            PW_SAVE: begin
                if (pwr_down)      pw_nx = PW_DOWN;
                else if (~|stalled) pw_nx = PW_RUN;
            end
            PW_DOWN: begin
                if (!pwr_down)     pw_nx = (|stalled) ? PW_SAVE : PW_RUN;
            end
            default:               pw_nx = PW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pw_st <= PW_RUN;
        else        pw_st <= pw_nx;
    end

    assign pwr_state = pw_st;
    assign run       = (pw_st == PW_RUN);

    vsp_rx #(.W(SAMPLE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .bit_fall (bit_fall),
        .sync_lvl (lvl[I_RFS]),
        .din      (lvl[I_RSD]),
        .sample   (rx_sample),
        .valid    (rx_valid)
    );

    vsp_tx #(.W(SAMPLE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .bit_rise  (bit_rise),
        .sync_lvl  (lvl[I_TFS]),
        .load      (tx_valid),
        .load_data (tx_sample),
        .sdata     (tx_sdata),
        .oe        (tx_oe)
    );

    // R10: power-down wins at the next edge
    a_r10_down_next: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (pwr_state == PW_DOWN));
    // R8/R9: an expired watchdog leaves RUN unless power-down is asserted
    a_r8_stall_to_save: assert property (@(posedge clk) disable iff (!rst_n)
        ((|stalled) && !pwr_down) |=> (pwr_state == PW_SAVE));
    // R12: RUN only when no watchdog had expired
    a_r12_run_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PW_RUN) |-> $past(~|stalled && !pwr_down));
endmodule

// File: tb/voice_serial_port_bench.sv
module voice_serial_port_bench;
    localparam int STALL_LIM = 1000;
    localparam int FBITS     = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bclk, rx_fsync, rx_sdata, tx_fsync, pwr_down, tx_valid;
    logic [7:0] tx_sample;
    logic [7:0] rx_sample;
    logic       rx_valid, tx_sdata, tx_oe;
    logic [1:0] pwr_state;

    int         n_chk  = 0;
    int         n_fail = 0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];
    logic [7:0] model_hold = 8'h00;
    bit         tx_expect  = 1'b0;

    always #4 clk = ~clk;

    voice_serial_port #(.STALL_LIMIT(STALL_LIM)) u_voice_serial_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .rx_fsync  (rx_fsync),
        .rx_sdata  (rx_sdata),
        .tx_fsync  (tx_fsync),
        .pwr_down  (pwr_down),
        .tx_sample (tx_sample),
        .tx_valid  (tx_valid),
        .rx_sample (rx_sample),
        .rx_valid  (rx_valid),
        .tx_sdata  (tx_sdata),
        .tx_oe     (tx_oe),
        .pwr_state (pwr_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // receive monitor: compare every valid pulse with the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rx_valid === 1'b1) begin
            if (rx_q.size() == 0) chk(1'b0, "R11 unexpected rx_valid", 1, 0);
            else begin
                logic [7:0] e;
                e = rx_q.pop_front();
                chk(rx_sample === e, "R2/R3/R5 rx_sample", int'(rx_sample), int'(e));
            end
        end
    end

    // transmit monitor: samples the line where the far end would
    int         tpos = 100;
    logic       tps  = 1'b0;
    logic [7:0] tbits;
    always @(negedge bclk) begin
        if (tx_fsync && !tps) tpos = 0;
        else if (tpos < 100)  tpos++;
        tps = tx_fsync;
        if (tx_expect) begin
            if (tpos < 8) begin
                tbits = {tbits[6:0], tx_sdata};
                if (!tx_oe) chk(1'b0, "R4 tx_oe low inside window", 0, 1);
                if (tpos == 7) begin
                    if (tx_q.size() == 0) chk(1'b0, "R4 unexpected tx byte", int'(tbits), 0);
                    else begin
                        logic [7:0] e;
                        e = tx_q.pop_front();
                        chk(tbits === e, "R4/R6/R7 tx byte", int'(tbits), int'(e));
                    end
                end
            end else if (tpos == 8) begin
                chk(tx_oe === 1'b0, "R4 tx_oe after eighth bit", int'(tx_oe), 0);
            end
        end else begin
            chk(tx_oe === 1'b0, "R11 tx_oe while idle", int'(tx_oe), 0);
        end
    end

    // one bit time: rise half then fall half, optional tx_valid at cycle sk
    task automatic bit_step(input logic d, input logic rs, input logic ts,
                            input int sk, input logic [7:0] sv);
        bclk = 1'b1; rx_sdata = d; rx_fsync = rs; tx_fsync = ts;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            tx_valid = (i == sk);
            if (i == sk) tx_sample = sv;
        end
        bclk = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            tx_valid = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] rb, input int roff, input int rlen,
                         input int toff, input int tlen,
                         input int sbit, input int sk, input logic [7:0] sval,
                         input bit exp_rx, input bit exp_tx);
        if (exp_tx && toff >= 0) begin
            if (sbit >= 0 && (sbit < toff || (sbit == toff && sk <= 2))) tx_q.push_back(sval);
            else tx_q.push_back(model_hold);
        end
        if (sbit >= 0) model_hold = sval;
        if (exp_rx && roff >= 0) rx_q.push_back(rb);
        tx_expect = exp_tx;
        for (int b = 0; b < FBITS; b++) begin
            logic rs, ts, d;
            rs = (roff >= 0) && (b >= roff) && (b < roff + rlen);
            ts = (toff >= 0) && (b >= toff) && (b < toff + tlen);
            d  = (roff >= 0 && b >= roff && b < roff + 8) ? rb[7 - (b - roff)] : b[0];
            bit_step(d, rs, ts, (b == sbit) ? sk : -1, sval);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bclk = 1'b0; rx_fsync = 1'b0; rx_sdata = 1'b0;
        tx_fsync = 1'b0; pwr_down = 1'b0; tx_valid = 1'b0; tx_sample = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(rx_valid === 1'b0, "R1 rx_valid reset", int'(rx_valid), 0);
        chk(tx_oe === 1'b0, "R1 tx_oe reset", int'(tx_oe), 0);
        chk(pwr_state === 2'b00, "R1 pwr_state reset", int'(pwr_state), 0);

        // R2 R5 R6: early load, distinct offsets
        frame(8'hA5, 0, 1, 2, 1, 0, 4, 8'h3C, 1, 1);
        // R3: sync held three bits; R6 resend
        frame(8'h5A, 3, 3, 0, 2, -1, 0, 8'h00, 1, 1);
        // R7: load in the launch cycle goes out now
        frame(8'h81, 8, 1, 7, 1, 7, 2, 8'hC3, 1, 1);
        // R7: load one cycle late waits a frame
        frame(8'h7E, 5, 1, 4, 1, 4, 3, 8'h96, 1, 1);
        frame(8'hFF, 0, 1, 0, 1, -1, 0, 8'h00, 1, 1);
        frame(8'h00, 2, 1, 6, 1, 10, 1, 8'h11, 1, 1);
        chk(pwr_state === 2'b00, "R8 no false stall", int'(pwr_state), 0);

        // R10 power-down
        pwr_down = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(pwr_state === 2'b10, "R10 pwr_state down", int'(pwr_state), 2);
        frame(8'hE7, 0, 1, 0, 1, 3, 4, 8'h44, 0, 0);
        pwr_down = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(pwr_state === 2'b00, "R12 run after power-down", int'(pwr_state), 0);
        frame(8'h24, 1, 1, 1, 1, -1, 0, 8'h00, 1, 1);

        // R8 bit-clock stall
        tx_expect = 1'b0;
        repeat (1500) @(negedge clk);
        chk(pwr_state === 2'b01, "R8 save on bit-clock stall", int'(pwr_state), 1);
        chk(tx_oe === 1'b0, "R11 tx_oe in save", int'(tx_oe), 0);
        frame(8'h3F, 0, 1, 4, 1, -1, 0, 8'h00, 0, 0);
        chk(pwr_state === 2'b00, "R12 run after recovery", int'(pwr_state), 0);
        frame(8'h99, 2, 1, 3, 1, -1, 0, 8'h00, 1, 1);

        // R9 transmit sync stall with the bit clock running
        for (int k = 0; k < 5; k++) frame(8'h00, -1, 1, -1, 1, -1, 0, 8'h00, 0, 0);
        chk(pwr_state === 2'b01, "R9 save on tx sync stall", int'(pwr_state), 1);
        frame(8'hB2, 0, 1, -1, 1, -1, 0, 8'h00, 0, 0);
        frame(8'h6D, 0, 1, 4, 1, -1, 0, 8'h00, 0, 0);
        chk(pwr_state === 2'b00, "R12 run after tx sync returns", int'(pwr_state), 0);
        frame(8'h5C, 6, 1, 0, 1, -1, 0, 8'h00, 1, 1);

        repeat (20) @(negedge clk);
        chk(rx_q.size() == 0, "R2 rx samples missing", rx_q.size(), 0);
        chk(tx_q.size() == 0, "R4 tx bytes missing", tx_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule